// File: doc/BRIEF.md
# Power-Fail Write Guard and Supply Source Selector

This block turns three already-digitized supply comparator flags into two control decisions for a timekeeping macro. The first is a write-protect level that shields the clock and storage registers while the main supply is unreliable. The second is a select line that powers the core from either the main rail or the backup cell. The flags are asynchronous to the block clock, so each one goes through a two-stage synchronizer before any decision uses it.

Write protection rises as soon as the synchronized flag reports that the main supply is below the power-fail threshold. It falls only after the supply has stayed valid for a programmable number of clock cycles, `TCSR_CYCLES`. A new dip during that interval restarts the count. Reset asserts protection and loads the full count, so protection also lifts only after a complete valid interval that follows reset.

The source rule depends on the parameter `LOW_VOLT`. With `LOW_VOLT = 1`, the choice uses the power-fail threshold and the backup level. With `LOW_VOLT = 0`, the only test is whether the main supply is below the backup voltage.

Register writes reach the register file through a valid/ready pass-through. While protection is clear, the pass-through is transparent: `reg_valid` follows `wr_valid`, `wr_ready` follows `reg_ready`, and the address and data are forwarded unchanged. Back-pressure from the register file then stalls the writer. While protection is set, the block accepts every offered write at once (`wr_ready = 1`), discards it, keeps `reg_valid` low and sets a sticky blocked flag. Only reset clears that flag.

Top module: `pwr_guard`

## Requirements
- R1: While `rst_n` is low, `wr_protect` = 1, `src_backup` = 1 and `wr_blocked` = 0. When reset is released with all flags low, `wr_protect` stays 1 through rising edge `TCSR_CYCLES+1` after the release and reads 0 after edge `TCSR_CYCLES+2`.
- R2: When `vcc_lo_pf` goes from 0 to 1 while protection is clear, `wr_protect` is still 0 after the second rising edge and is 1 after the third rising edge.
- R3: When `vcc_lo_pf` goes from 1 to 0 and stays 0, `wr_protect` stays 1 through rising edge `TCSR_CYCLES+1` and is 0 after rising edge `TCSR_CYCLES+2`.
- R4: A return of `vcc_lo_pf` to 1 during the recovery interval keeps `wr_protect` at 1 and restarts the count. Release then follows the timing of R3, measured from the last 1-to-0 change.
- R5: With `LOW_VOLT = 1`, `src_backup` = 1 (backup cell) exactly when `vcc_lo_pf` = 1 and either `bk_lo_pf` = 0 or `vcc_lo_bk` = 1. Otherwise `src_backup` = 0 (main supply), which always holds when `vcc_lo_pf` = 0.
- R6: With `LOW_VOLT = 0`, `src_backup` equals `vcc_lo_bk`. The other two flags have no effect on it.
- R7: `src_backup` follows a flag change after the third rising edge, and still shows the old value after the second rising edge.
- R8: While `wr_protect` = 0, `reg_valid` = `wr_valid` and `wr_ready` = `reg_ready`, and `reg_addr`/`reg_data` carry `wr_addr`/`wr_data`. Each accepted write appears once, in order.
- R9: While `wr_protect` = 1, `reg_valid` = 0 and `wr_ready` = 1. An offered write is discarded, and `wr_blocked` reads 1 after the next rising edge. Writes accepted while protection is clear leave `wr_blocked` at 0.
- R10: Once set, `wr_blocked` stays 1 until reset, including across a later release of protection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_lo_pf | input | 1 | Main supply below power-fail threshold (asynchronous) |
| vcc_lo_bk | input | 1 | Main supply below backup cell voltage (asynchronous) |
| bk_lo_pf | input | 1 | Backup cell below power-fail threshold (asynchronous) |
| wr_valid | input | 1 | Write request offered |
| wr_ready | output | 1 | Write request taken (forwarded or discarded) |
| wr_addr | input | AW | Write register address |
| wr_data | input | DW | Write data |
| reg_valid | output | 1 | Write forwarded to the register file |
| reg_ready | input | 1 | Register file can take a write |
| reg_addr | output | AW | Forwarded address |
| reg_data | output | DW | Forwarded data |
| wr_protect | output | 1 | Clock and storage registers write-protected |
| src_backup | output | 1 | 1 selects the backup cell, 0 selects the main supply |
| wr_blocked | output | 1 | Sticky: a write was discarded under protection |

## Verification
The bench times the protection release to the exact edge, both after reset and after a supply dip. A timer off by one cycle, or one that starts counting from the rising flag instead of the falling one, misses the edge-`TCSR_CYCLES+2` check. A supply dip in the middle of recovery must restart the count; a design that only pauses or ignores the dip releases protection early. All eight flag combinations are applied to both variants, so a swapped or partial low-voltage rule shows up as a wrong source select. The bench also offers writes under protection, under back-pressure and after recovery: a leak under protection, a lost or duplicated forwarded write, or a blocked flag that clears on recovery each breaks the scoreboard or a flag check.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;

  typedef struct packed {
    logic vcc_lo_pf;
    logic vcc_lo_bk;
    logic bk_lo_pf;
  } sup_flags_t;

  localparam int FLAG_W = $bits(sup_flags_t);

  typedef enum logic {
    SRC_MAIN   = 1'b0,
    SRC_BACKUP = 1'b1
  } src_e;

endpackage

// File: rtl/pwr_flag_sync.sv
module pwr_flag_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stage_q [STAGES];

  // reset value is all ones: every supply is treated as failed until sampled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
    end else begin
      stage_q[0] <= d_async;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/pwr_recovery_timer.sv
module pwr_recovery_timer #(
  parameter int TCSR_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  output logic protect
);

  localparam int CW = $clog2(TCSR_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(TCSR_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          prot_q;

  always_comb begin
    if (fault)              cnt_d = RELOAD;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= RELOAD;
      prot_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      prot_q <= (cnt_d != '0);
    end
  end

  assign protect = prot_q;

endmodule

// File: rtl/pwr_source_sel.sv
module pwr_source_sel
  import pwr_guard_pkg::*;
#(
  parameter bit LOW_VOLT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  sup_flags_t flags,
  output src_e       src
);

  src_e src_d, src_q;

  generate
    if (LOW_VOLT) begin : g_low_volt
      always_comb begin
        if (flags.vcc_lo_pf && (!flags.bk_lo_pf || flags.vcc_lo_bk))
          src_d = SRC_BACKUP;
        else
          src_d = SRC_MAIN;
      end
    end else begin : g_standard
      logic unused_flags;
      assign unused_flags = flags.vcc_lo_pf ^ flags.bk_lo_pf;
      always_comb src_d = flags.vcc_lo_bk ? SRC_BACKUP : SRC_MAIN;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= SRC_BACKUP;
    else        src_q <= src_d;
  end

  assign src = src_q;

endmodule

// File: rtl/pwr_write_gate.sv
module pwr_write_gate #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          protect,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          reg_valid,
  input  logic          reg_ready,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_data,
  output logic          blocked
);

  logic blocked_q;

  assign reg_valid = wr_valid && !protect;
  assign wr_ready  = protect || reg_ready;
  assign reg_addr  = wr_addr;
  assign reg_data  = wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    blocked_q <= 1'b0;
    else if (wr_valid && protect)  blocked_q <= 1'b1;
  end

  assign blocked = blocked_q;

endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
  import pwr_guard_pkg::*;
#(
  parameter bit LOW_VOLT    = 1'b1,
  parameter int TCSR_CYCLES = 40,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 5,
  parameter int DW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vcc_lo_pf,
  input  logic          vcc_lo_bk,
  input  logic          bk_lo_pf,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          reg_valid,
  input  logic          reg_ready,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_data,
  output logic          wr_protect,
  output logic          src_backup,
  output logic          wr_blocked
);

  sup_flags_t flags_raw, flags_s;
  src_e       src;
  logic       prot;

  assign flags_raw = '{vcc_lo_pf: vcc_lo_pf, vcc_lo_bk: vcc_lo_bk, bk_lo_pf: bk_lo_pf};

  pwr_flag_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (flags_raw),
    .q_sync  (flags_s)
  );

  pwr_recovery_timer #(.TCSR_CYCLES(TCSR_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .fault   (flags_s.vcc_lo_pf),
    .protect (prot)
  );

  pwr_source_sel #(.LOW_VOLT(LOW_VOLT)) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .flags (flags_s),
    .src   (src)
  );

  pwr_write_gate #(.AW(AW), .DW(DW)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .protect   (prot),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .reg_valid (reg_valid),
    .reg_ready (reg_ready),
    .reg_addr  (reg_addr),
    .reg_data  (reg_data),
    .blocked   (wr_blocked)
  );

  assign wr_protect = prot;
  assign src_backup = (src == SRC_BACKUP);

endmodule

// File: rtl/pwr_guard_chk.sv
module pwr_guard_chk #(
  parameter bit LOW_VOLT = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic pf_s,
  input logic lobk_s,
  input logic bklo_s,
  input logic prot,
  input logic sel,
  input logic wr_valid,
  input logic wr_ready,
  input logic reg_valid,
  input logic reg_ready,
  input logic blocked
);

  // R2: a synchronized fault sets protection on the next edge
  assert_prot_on_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pf_s |=> prot);

  // R3: protection never falls while the supply flag is still bad
  assert_release_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot) |-> (!pf_s && !$past(pf_s)));

  // R9: nothing leaks to the register file under protection
  assert_no_leak_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prot |-> (!reg_valid && wr_ready));

  assert_blocked_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && prot) |=> blocked);

  // R10: blocked flag is sticky
  assert_blocked_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> blocked);

  // R8: transparent when unprotected
  assert_pass_through_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !prot |-> (reg_valid == wr_valid && wr_ready == reg_ready));

  generate
    if (LOW_VOLT) begin : g_lv
      // R5: low-voltage switchover rule, one edge after the synchronized flags
      assert_lv_rule_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sel == $past(pf_s && (!bklo_s || lobk_s))));
    end else begin : g_std
      logic unused_bklo;
      assign unused_bklo = bklo_s;
      // R6: standard rule follows only the backup comparison
      assert_std_rule_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sel == $past(lobk_s)));
    end
  endgenerate

endmodule

bind pwr_guard pwr_guard_chk #(.LOW_VOLT(LOW_VOLT)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pf_s      (flags_s.vcc_lo_pf),
  .lobk_s    (flags_s.vcc_lo_bk),
  .bklo_s    (flags_s.bk_lo_pf),
  .prot      (wr_protect),
  .sel       (src_backup),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .reg_valid (reg_valid),
  .reg_ready (reg_ready),
  .blocked   (wr_blocked)
);

// File: tb/test_pwr_guard.sv
`timescale 1ns/100ps
module test_pwr_guard;

  localparam int TCSR = 20;
  localparam int AW   = 5;
  localparam int DW   = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic vcc_lo_pf, vcc_lo_bk, bk_lo_pf;
  logic wr_valid, wr_ready, reg_valid, reg_ready;
  logic [AW-1:0] wr_addr, reg_addr;
  logic [DW-1:0] wr_data, reg_data;
  logic wr_protect, src_backup, wr_blocked;

  logic s_wr_ready, s_reg_valid, s_protect, s_src, s_blocked;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_data;

  pwr_guard #(.LOW_VOLT(1'b1), .TCSR_CYCLES(TCSR), .AW(AW), .DW(DW)) i_pwr_guard (
    .clk(clk), .rst_n(rst_n),
    .vcc_lo_pf(vcc_lo_pf), .vcc_lo_bk(vcc_lo_bk), .bk_lo_pf(bk_lo_pf),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_addr(reg_addr), .reg_data(reg_data),
    .wr_protect(wr_protect), .src_backup(src_backup), .wr_blocked(wr_blocked)
  );

  pwr_guard #(.LOW_VOLT(1'b0), .TCSR_CYCLES(TCSR), .AW(AW), .DW(DW)) i_pwr_guard_std (
    .clk(clk), .rst_n(rst_n),
    .vcc_lo_pf(vcc_lo_pf), .vcc_lo_bk(vcc_lo_bk), .bk_lo_pf(bk_lo_pf),
    .wr_valid(1'b0), .wr_ready(s_wr_ready), .wr_addr('0), .wr_data('0),
    .reg_valid(s_reg_valid), .reg_ready(1'b1), .reg_addr(s_addr), .reg_data(s_data),
    .wr_protect(s_protect), .src_backup(s_src), .wr_blocked(s_blocked)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } item_t;
  item_t exp_q[$];

  // monitor: pops the scoreboard on every forwarded handshake (R8)
  always @(negedge clk) begin
    if (rst_n && reg_valid && reg_ready) begin
      if (exp_q.size() == 0) begin
        chk("R8 unexpected forwarded write", {reg_addr, reg_data}, 32'hffff_ffff);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        chk("R8 forwarded write", {reg_addr, reg_data}, {e.a, e.d});
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit pass);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    if (pass) exp_q.push_back('{a: a, d: d});
    #0.5;
    if (!pass) begin
      chk("R9 reg_valid low under protection", reg_valid, 0);
      chk("R9 wr_ready high under protection", wr_ready, 1);
    end
    step(1);
    wr_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {vcc_lo_pf, vcc_lo_bk, bk_lo_pf} = 3'b000;
    wr_valid = 1'b0; wr_addr = '0; wr_data = '0; reg_ready = 1'b1;
    step(3);
    chk("R1 protect in reset", wr_protect, 1);
    chk("R1 source in reset", src_backup, 1);
    chk("R1 blocked in reset", wr_blocked, 0);
    rst_n = 1'b1;
    step(TCSR + 1);
    chk("R1 protect held after reset", wr_protect, 1);
    step(1);
    chk("R1 protect released after reset", wr_protect, 0);
    chk("R5 main supply selected", src_backup, 0);
    chk("R6 main supply selected", s_src, 0);

    // pass-through writes and back-pressure
    send(5'd3, 8'hA5, 1'b1);
    send(5'd7, 8'h3C, 1'b1);
    reg_ready = 1'b0;
    wr_valid = 1'b1; wr_addr = 5'd12; wr_data = 8'h5A;
    #0.5;
    chk("R8 back-pressure ready", wr_ready, 0);
    chk("R8 valid forwarded", reg_valid, 1);
    step(2);
    exp_q.push_back('{a: 5'd12, d: 8'h5A});
    reg_ready = 1'b1;
    step(1);
    wr_valid = 1'b0;
    chk("R9 no block for accepted writes", wr_blocked, 0);
    chk("R8 scoreboard drained", exp_q.size(), 0);

    // fault onset: protection and low-voltage switchover latency
    vcc_lo_pf = 1'b1;
    step(2);
    chk("R2 protect not yet", wr_protect, 0);
    chk("R7 source not yet", src_backup, 0);
    step(1);
    chk("R2 protect asserted", wr_protect, 1);
    chk("R7 backup after three edges", src_backup, 1);
    chk("R6 standard ignores pf", s_src, 0);

    send(5'd9, 8'h11, 1'b0);
    chk("R9 blocked set", wr_blocked, 1);

    // all flag combinations on both variants
    for (int c = 0; c < 8; c++) begin
      logic pf, lb, bp;
      {pf, lb, bp} = 3'(c);
      vcc_lo_pf = pf; vcc_lo_bk = lb; bk_lo_pf = bp;
      step(3);
      chk($sformatf("R5 low-voltage rule combo %0d", c), src_backup, pf & (~bp | lb));
      chk($sformatf("R6 standard rule combo %0d", c), s_src, lb);
    end

    // recovery, then a dip that restarts the count
    {vcc_lo_pf, vcc_lo_bk, bk_lo_pf} = 3'b000;
    step(12);
    chk("R3 protect held in recovery", wr_protect, 1);
    vcc_lo_pf = 1'b1;
    step(3);
    chk("R4 protect held during dip", wr_protect, 1);
    vcc_lo_pf = 1'b0;
    step(TCSR + 1);
    chk("R4 protect held after restart", wr_protect, 1);
    step(1);
    chk("R4 protect released after restart", wr_protect, 0);
    chk("R3 standard instance released", s_protect, 0);
    chk("R10 blocked survives recovery", wr_blocked, 1);

    send(5'd2, 8'h77, 1'b1);
    step(1);
    chk("R8 scoreboard drained after recovery", exp_q.size(), 0);

    // straightforward release timing
    vcc_lo_pf = 1'b1;
    step(5);
    vcc_lo_pf = 1'b0;
    step(TCSR + 1);
    chk("R3 protect held", wr_protect, 1);
    step(1);
    chk("R3 protect released", wr_protect, 0);

    rst_n = 1'b0;
    step(1);
    chk("R10 blocked cleared only by reset", wr_blocked, 0);
    chk("R1 protect in second reset", wr_protect, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule